// File: doc/BRIEF.md
# Recirculating Character Memory Transfer Controller

This block moves characters between a pair of small buffers and a character store that behaves as a loop. The store holds the display text. One slot of the loop passes a fixed entry point on every clock. A cursor position names the slot that the next transfer uses. A transfer can only take place in the cycle in which the cursor slot is at the entry point. Each completed transfer advances the cursor by one slot and raises a one-cycle step pulse.

In receive mode the controller watches an incoming byte stream for a start-of-text byte followed directly by the block's address byte. After that header it loads each further byte into a single receive buffer. When the cursor slot comes round, it writes the buffered byte into that slot. Control bytes are filtered before they reach the buffer. An escape byte lets the next control byte through. A few codes are always dropped. In transmit mode, entered while receive is disabled, the controller reads the byte under the cursor into a small transmit queue. Because the following slot reaches the entry point on the very next clock, it can take consecutive characters on consecutive cycles for as long as the queue has room.

Top module: `charmem_xfer_ctrl`

## Requirements
- R1: After reset the cursor is 0, the loop position is 0, every slot holds 0x20, `rx_ready_o` is 1, and `rx_active_o`, `tx_valid_o` and `cursor_step_o` are 0.
- R2: `rx_active_o` rises only in the cycle after an accepted address byte (default 0x31) that directly follows an accepted start-of-text byte 0x02. A repeated 0x02 keeps the header search at its middle step, and any other byte restarts the search. Header bytes and bytes received before the header are never stored.
- R3: While receive is active and the buffer is full, `rx_ready_o` is 0. A byte offered in that state is ignored and leaves the buffered byte unchanged.
- R4: A buffered byte is written into the cursor slot. In the same clock the cursor advances by one, and `cursor_step_o` is 1 for exactly that one cycle for each transfer.
- R5: The loop position counts 0 to N-1 and wraps, one step per clock. A transfer happens only in a cycle in which the loop position equals the cursor.
- R6: A byte 0x1B arriving with no escape pending is not stored and sets escape-pending. While escape is pending, the next byte is stored unless it is 0x00, 0x05 or 0x7F, and escape-pending then clears. This includes a second 0x1B.
- R7: The bytes 0x00, 0x05 and 0x7F are never stored. Bytes outside 0x20..0x7E that arrive without an escape pending are not stored.
- R8: While `rx_en_i` is 0, the header search restarts, escape-pending clears, a buffered byte is discarded and received bytes are ignored.
- R9: With `tx_req_i` at 1, `rx_en_i` at 0 and queue room, the byte in the cursor slot is pushed into the transmit queue, and the cursor advances with a step pulse.
- R10: The transmit queue holds up to TX_DEPTH bytes (default 2) in order. `tx_valid_o` is 1 while the queue is not empty, and `tx_ack_i` removes the head. With no acknowledge, taking stops when the queue is full and the head byte stays stable.
- R11: The cursor wraps from N-1 (default 63) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable (message window) |
| rx_valid_i | input | 1 | Incoming byte present |
| rx_data_i | input | 8 | Incoming byte |
| rx_ready_o | output | 1 | Incoming byte can be taken |
| rx_active_o | output | 1 | Header seen, text being received |
| tx_req_i | input | 1 | Transmit request |
| tx_data_o | output | 8 | Head byte of transmit queue |
| tx_valid_o | output | 1 | Transmit queue not empty |
| tx_ack_i | input | 1 | Remove head byte |
| cursor_o | output | 6 | Cursor slot |
| cursor_step_o | output | 1 | Cursor advanced this cycle |

## Verification
A directed receive message mixes stray bytes before the header, a broken header, a header cut by dropping the enable, printable text, and an escaped carriage return next to a bare one and a delete. A full transmit readback of all 64 slots then shows which bytes were stored and where. This separates filtering faults from faults in slot placement, and checks that the cursor returns to its start after a wrap.

A held acknowledge shows that taking stops once the queue is full. Long random traffic with the enable toggling, a reference model in the bench, and compares on every cycle separate errors in timing against the loop position from errors in data.

// File: rtl/charmem_xfer_pkg.sv
package charmem_xfer_pkg;
  localparam logic [7:0] CH_NUL   = 8'h00;
  localparam logic [7:0] CH_SOT   = 8'h02;
  localparam logic [7:0] CH_ENQ   = 8'h05;
  localparam logic [7:0] CH_ESC   = 8'h1B;
  localparam logic [7:0] CH_DEL   = 8'h7F;
  localparam logic [7:0] CH_SPACE = 8'h20;

  typedef enum logic [1:0] {HDR_HUNT, HDR_SOT, HDR_ACTIVE} hdr_state_e;

  function automatic logic is_text(input logic [7:0] c);
    return (c >= 8'h20) && (c <= 8'h7E);
  endfunction

  function automatic logic is_never(input logic [7:0] c);
    return (c == CH_NUL) || (c == CH_ENQ) || (c == CH_DEL);
  endfunction
endpackage

// File: rtl/charmem_rx_front.sv
module charmem_rx_front
  import charmem_xfer_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'h31
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_en_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       take_i,
  output logic       rx_ready_o,
  output logic       active_o,
  output logic       full_o,
  output logic [7:0] buf_o
);
  hdr_state_e state_q;
  logic       esc_q, full_q;
  logic [7:0] buf_q;
  logic       accept, keep_c, esc_set_c;

  assign rx_ready_o = !(state_q == HDR_ACTIVE && full_q);
  assign accept     = rx_en_i && rx_valid_i && rx_ready_o;
  assign keep_c     = (is_text(rx_data_i) || esc_q) && !is_never(rx_data_i);
  assign esc_set_c  = !esc_q && (rx_data_i == CH_ESC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HDR_HUNT;
      esc_q   <= 1'b0;
      full_q  <= 1'b0;
      buf_q   <= CH_SPACE;
    end else if (!rx_en_i) begin
      state_q <= HDR_HUNT;
      esc_q   <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      if (take_i) full_q <= 1'b0;
      if (accept) begin
        unique case (state_q)
          HDR_HUNT: if (rx_data_i == CH_SOT) state_q <= HDR_SOT;
          HDR_SOT: begin
            if (rx_data_i == DEV_ADDR)    state_q <= HDR_ACTIVE;
            else if (rx_data_i != CH_SOT) state_q <= HDR_HUNT;
          end
          HDR_ACTIVE: begin
            full_q <= keep_c;
            if (keep_c) buf_q <= rx_data_i;
            esc_q <= esc_set_c;
          end
          default: state_q <= HDR_HUNT;
        endcase
      end
    end
  end

  assign active_o = (state_q == HDR_ACTIVE);
  assign full_o   = full_q;
  assign buf_o    = buf_q;

  // refused byte leaves buffer alone
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_i && rx_valid_i && !rx_ready_o && !take_i) |=> (full_q && $stable(buf_q)));

  assert_never_code_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && state_q == HDR_ACTIVE && is_never(rx_data_i)) |=> !full_q);

  assert_hdr_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> ($past(rx_valid_i) && $past(rx_data_i) == DEV_ADDR));

  assert_disable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> (!full_q && !active_o));
endmodule

// File: rtl/charmem_loop_mem.sv
module charmem_loop_mem
  import charmem_xfer_pkg::*;
#(
  parameter int N  = 64,
  parameter int W  = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] cursor_i,
  input  logic          wr_en_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          hit_o,
  output logic [W-1:0]  rd_data_o
);
  logic [AW-1:0] rot_q;
  logic [W-1:0]  mem_q [N];

  assign hit_o     = (rot_q == cursor_i);
  assign rd_data_o = mem_q[rot_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rot_q <= '0;
      for (int i = 0; i < N; i++) mem_q[i] <= W'(CH_SPACE);
    end else begin
      rot_q <= (rot_q == AW'(N-1)) ? '0 : rot_q + 1'b1;
      if (wr_en_i) mem_q[rot_q] <= wr_data_i;
    end
  end

  assert_rot_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_q == AW'(N-1)) |=> (rot_q == '0));

  assert_rot_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rot_q != AW'(N-1)) |=> (rot_q == $past(rot_q) + 1'b1));
endmodule

// File: rtl/charmem_tx_fifo.sv
module charmem_tx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         ack_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         space_o
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign valid_o = (cnt_q != '0);
  assign space_o = (cnt_q < CW'(DEPTH));
  assign data_o  = slot_q[rd_q];
  assign pop     = ack_i && valid_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      if (push_i) begin
        slot_q[wr_q] <= data_i;
        wr_q <= nxt(wr_q);
      end
      if (pop) rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop);
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> space_o);

  assert_head_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ack_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/charmem_xfer_ctrl.sv
module charmem_xfer_ctrl
  import charmem_xfer_pkg::*;
#(
  parameter int         N        = 64,
  parameter int         TX_DEPTH = 2,
  parameter logic [7:0] DEV_ADDR = 8'h31,
  localparam int        AW       = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          rx_ready_o,
  output logic          rx_active_o,
  input  logic          tx_req_i,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ack_i,
  output logic [AW-1:0] cursor_o,
  output logic          cursor_step_o
);
  logic [AW-1:0] cursor_q;
  logic          step_q;
  logic          hit, rx_full, rx_wr, tx_push, tx_space, adv;
  logic [7:0]    rx_buf, rd_data;

  charmem_rx_front #(.DEV_ADDR(DEV_ADDR)) rx_i (
    .clk_i, .rst_ni, .rx_en_i, .rx_valid_i, .rx_data_i,
    .take_i(rx_wr), .rx_ready_o, .active_o(rx_active_o),
    .full_o(rx_full), .buf_o(rx_buf)
  );

  charmem_loop_mem #(.N(N), .W(8)) mem_i (
    .clk_i, .rst_ni, .cursor_i(cursor_q), .wr_en_i(rx_wr),
    .wr_data_i(rx_buf), .hit_o(hit), .rd_data_o(rd_data)
  );

  charmem_tx_fifo #(.DEPTH(TX_DEPTH), .W(8)) txq_i (
    .clk_i, .rst_ni, .push_i(tx_push), .data_i(rd_data), .ack_i(tx_ack_i),
    .valid_o(tx_valid_o), .data_o(tx_data_o), .space_o(tx_space)
  );

  // single transfer enable: one direction per slot pass
  assign rx_wr   = rx_en_i && rx_active_o && rx_full && hit;
  assign tx_push = !rx_en_i && tx_req_i && tx_space && hit;
  assign adv     = rx_wr || tx_push;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cursor_q <= '0;
      step_q   <= 1'b0;
    end else begin
      step_q <= adv;
      if (adv) cursor_q <= (cursor_q == AW'(N-1)) ? '0 : cursor_q + 1'b1;
    end
  end

  assign cursor_o      = cursor_q;
  assign cursor_step_o = step_q;

  assert_wr_at_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |-> hit);

  assert_cursor_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && cursor_q == AW'(N-1)) |=> (cursor_q == '0));

  assert_step_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cursor_step_o |-> (cursor_q != $past(cursor_q)));
endmodule

// File: tb/charmem_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module charmem_xfer_ctrl_tb_top;
  localparam logic [7:0] ADDR = 8'h31;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic rx_en = 1'b0, rx_valid = 1'b0, tx_req = 1'b0, tx_ack = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, rx_active, tx_valid, step;
  logic [7:0] tx_data;
  logic [5:0] cursor;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit live = 0;

  always #10 clk = ~clk;

  charmem_xfer_ctrl dut_i (
    .clk_i(clk), .rst_ni, .rx_en_i(rx_en), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_ready_o(rx_ready), .rx_active_o(rx_active), .tx_req_i(tx_req),
    .tx_data_o(tx_data), .tx_valid_o(tx_valid), .tx_ack_i(tx_ack),
    .cursor_o(cursor), .cursor_step_o(step)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit f_text(input logic [7:0] c);
    return c >= 8'h20 && c <= 8'h7E;
  endfunction
  function automatic bit f_never(input logic [7:0] c);
    return c == 8'h00 || c == 8'h05 || c == 8'h7F;
  endfunction
  function automatic bit f_keep(input logic [7:0] c, input bit esc);
    return (f_text(c) || esc) && !f_never(c);
  endfunction

  // reference model
  int m_st, m_rot, m_cur;
  bit m_esc, m_full, m_step;
  logic [7:0] m_buf;
  logic [7:0] m_mem [64];
  logic [7:0] m_q [$];

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_rot = 0; m_cur = 0; m_esc = 0; m_full = 0; m_step = 0; m_buf = 8'h20;
      for (int i = 0; i < 64; i++) m_mem[i] = 8'h20;
      m_q.delete();
    end else begin
      bit hit, rdy, acc, rxwr, txp, pop;
      hit  = (m_rot == m_cur);
      rdy  = !(m_st == 2 && m_full);
      acc  = rx_en && rx_valid && rdy;
      rxwr = rx_en && m_full && m_st == 2 && hit;
      txp  = tx_req && !rx_en && hit && (m_q.size() < 2);
      pop  = tx_ack && (m_q.size() > 0);
      if (pop) void'(m_q.pop_front());
      if (txp) m_q.push_back(m_mem[m_rot]);
      if (rxwr) m_mem[m_rot] = m_buf;
      m_step = rxwr || txp;
      if (m_step) m_cur = (m_cur + 1) % 64;
      m_rot = (m_rot + 1) % 64;
      if (!rx_en) begin
        m_st = 0; m_esc = 0; m_full = 0;
      end else begin
        if (rxwr) m_full = 0;
        if (acc) begin
          case (m_st)
            0: if (rx_data == 8'h02) m_st = 1;
            1: if (rx_data == ADDR) m_st = 2; else if (rx_data != 8'h02) m_st = 0;
            default: begin
              if (f_keep(rx_data, m_esc)) begin m_full = 1; m_buf = rx_data; end
              m_esc = !m_esc && rx_data == 8'h1B;
            end
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (live) begin
      chk("R4 R11 cursor", 32'(cursor), 32'(m_cur));
      chk("R5 step timing", 32'(step), 32'(m_step));
      chk("R3 ready", 32'(rx_ready), 32'(!(m_st == 2 && m_full)));
      chk("R2 R8 active", 32'(rx_active), 32'(m_st == 2));
      chk("R10 tx valid", 32'(tx_valid), 32'(m_q.size() > 0));
      if (m_q.size() > 0) chk("R9 tx data", 32'(tx_data), 32'(m_q[0]));
    end
  end

  task automatic send(input logic [7:0] b);
    do @(negedge clk); while (!rx_ready);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog act=%0d exp=done", cyc);
    finish_run();
  end

  initial begin
    logic [7:0] got [64];
    void'($urandom(32'd20240611));
    idle(2);
    // R1 reset state, taken while reset is still low
    chk("R1 cursor", 32'(cursor), 0);
    chk("R1 ready", 32'(rx_ready), 1);
    chk("R1 active", 32'(rx_active), 0);
    chk("R1 tx valid", 32'(tx_valid), 0);
    chk("R1 step", 32'(step), 0);
    rst_ni = 1'b1;
    live = 1;
    idle(2);

    rx_en = 1'b1;
    send(8'h5A);                  // before header: dropped
    send(8'h02); send(8'h51);     // wrong address
    idle(1);
    chk("R2 bad address", 32'(rx_active), 0);
    send(8'h02);
    rx_en = 1'b0; idle(2); rx_en = 1'b1;
    send(ADDR);
    idle(1);
    chk("R8 header restarted", 32'(rx_active), 0);
    send(8'h02); send(8'h02); send(ADDR);
    chk("R2 header seen", 32'(rx_active), 1);
    send(8'h41);                  // 'A' -> slot 0
    send(8'h1B); send(8'h0D);     // escaped CR -> slot 1
    send(8'h0D);                  // bare CR dropped
    send(8'h7F);                  // DEL dropped
    send(8'h1B); send(8'h05);     // ENQ dropped even escaped
    send(8'h42);                  // 'B' -> slot 2
    idle(70);
    chk("R4 cursor after text", 32'(cursor), 3);

    // readback of every slot through transmit
    rx_en = 1'b0;
    idle(2);
    tx_ack = 1'b1; tx_req = 1'b1;
    for (int n = 0; n < 64; ) begin
      @(negedge clk);
      if (tx_valid) begin
        got[n] = tx_data;
        n++;
        if (n == 64) tx_req = 1'b0;
      end
    end
    idle(3);
    tx_ack = 1'b0;
    chk("R11 cursor wrapped back", 32'(cursor), 3);
    chk("R4 slot0", 32'(got[61]), 32'h41);
    chk("R6 escaped ctrl slot1", 32'(got[62]), 32'h0D);
    chk("R7 slot2 no ctrl", 32'(got[63]), 32'h42);
    chk("R1 untouched slot", 32'(got[0]), 32'h20);

    // queue fills and stops without acknowledge
    tx_req = 1'b1;
    idle(80);
    chk("R10 fill stops", 32'(cursor), 5);
    chk("R10 head valid", 32'(tx_valid), 1);
    chk("R9 head data", 32'(tx_data), 32'h20);
    tx_req = 1'b0;
    tx_ack = 1'b1; idle(4); tx_ack = 1'b0;

    // random traffic against the model
    rx_en = 1'b1;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if ($urandom % 150 == 0) rx_en = ~rx_en;
      rx_valid = ($urandom % 2) == 0;
      case ($urandom % 16)
        0: rx_data = 8'h02;
        1: rx_data = ADDR;
        2: rx_data = 8'h1B;
        3: rx_data = 8'h7F;
        4: rx_data = 8'h00;
        5: rx_data = 8'h05;
        6: rx_data = 8'h0D;
        default: rx_data = 8'(8'h20 + $urandom % 95);
      endcase
      tx_req = ($urandom % 3) != 0;
      tx_ack = ($urandom % 2) == 0;
    end
    rx_valid = 1'b0;
    idle(4);
    finish_run();
  end
endmodule